// File: doc/BRIEF.md
# Posted Line Write Buffer with Software Drain

This block sits between a cache controller and a memory port. It accepts full-line writes on its upstream side: an address, 256 bits of data and a byte-enable mask. Each accepted write is parked in one of two slots. The slots are retired to memory over a valid/ready channel. Retirement runs continuously and in arrival order, so upstream writes are posted and the controller does not wait for memory.

Before a processor power domain is switched off, firmware must be sure that no line is still in flight. It writes the value 1 to a sync control input, which arms a drain. While the drain is armed, the sync status reads nonzero and no new writes are taken in. Once the last pending line has been handed to memory, the status falls to zero and upstream traffic resumes.

A separate power-down request is granted only while both slots are empty. While that request is held, intake is stopped, so the buffer cannot refill after a grant.

Top module: `cache_wbuf`

## Requirements
- R1: The buffer holds two slots. Each slot stores a line address, 256 bits of data and a 32-bit byte-enable mask, with bit n enabling byte n of the data. One memory beat carries all three fields of one slot together and unaltered.
- R2: Lines reach memory in the order they were accepted. While `mem_valid` is high and `mem_ready` is low, the address, data and mask stay stable.
- R3: A sync write whose data equals 1, made while lines are pending, makes `sync_status` read 1 from the next cycle onward. It returns to 0 in the cycle after the last pending line is transferred. A sync write of 1 made while the buffer is empty leaves `sync_status` at 0.
- R4: A sync write with any value other than 1 has no effect: `sync_status` stays 0 and `up_ready` stays high.
- R5: While `sync_status` is nonzero, `up_ready` is low. A write held on the upstream side during a drain is accepted only after the status has returned to 0, and it retires after the drained lines.
- R6: When both slots are occupied, `up_ready` is low. It rises in the cycle after a slot is retired.
- R7: `pwr_grant` is high only while the buffer is empty and `pwr_req` is high. While `pwr_req` is high, `up_ready` is low from the next cycle onward. `pwr_grant` rises in the cycle after the last pending line leaves.
- R8: After a synchronous reset, both slots are empty, `mem_valid` is low, `sync_status` is 0, `pwr_grant` is low and `up_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| up_valid | input | 1 | Upstream write request valid |
| up_ready | output | 1 | Buffer can take a write this cycle |
| up_addr | input | 32 | Line address of the upstream write |
| up_data | input | 256 | Line data of the upstream write |
| up_strb | input | 32 | Byte enables of the upstream write |
| mem_valid | output | 1 | A buffered line is offered to memory |
| mem_ready | input | 1 | Memory takes the offered line |
| mem_addr | output | 32 | Address of the head line |
| mem_data | output | 256 | Data of the head line |
| mem_strb | output | 32 | Byte enables of the head line |
| sync_we | input | 1 | Write strobe of the sync control |
| sync_wdata | input | 32 | Value written to the sync control |
| sync_status | output | 32 | Nonzero while a drain is in progress |
| pwr_req | input | 1 | Request to cut the processor domain |
| pwr_grant | output | 1 | Power cut may proceed |

## Verification
The assertions assume that upstream and memory follow the valid/ready rule: a request is held, with its fields unchanged, until the matching ready is seen. They also assume that `mem_ready` is only meaningful while `mem_valid` is high. The bench honours this. Each upstream write is kept on the bus until `up_ready` has been observed. The memory stall pattern changes only between clock edges. It never withdraws a beat, because the design alone decides `mem_valid`. In the mixed sweep, `sync_we` and `pwr_req` stay low, so the ordering checks see uninterrupted traffic under varying stall patterns.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  // value firmware writes to request a drain
  localparam int unsigned SYNC_ARM = 1;

  typedef enum logic {
    DRN_IDLE   = 1'b0,
    DRN_ACTIVE = 1'b1
  } drain_state_e;
endpackage

// File: rtl/wbuf_slots.sv
module wbuf_slots #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 256,
  parameter int unsigned SW    = DW / 8,
  parameter int unsigned PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] wr_strb,
  input  logic [PW-1:0] rd_idx,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [SW-1:0] rd_strb
);
  // storage without reset so the arrays map onto distributed or block RAM
  logic [AW-1:0] addr_mem [SLOTS];
  logic [DW-1:0] data_mem [SLOTS];
  logic [SW-1:0] strb_mem [SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      addr_mem[wr_idx] <= wr_addr;
      data_mem[wr_idx] <= wr_data;
      strb_mem[wr_idx] <= wr_strb;
    end
  end

  assign rd_addr = addr_mem[rd_idx];
  assign rd_data = data_mem[rd_idx];
  assign rd_strb = strb_mem[rd_idx];
endmodule

// File: rtl/wbuf_queue_ctrl.sv
module wbuf_queue_ctrl #(
  parameter int unsigned SLOTS = 2,
  parameter int unsigned PW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  parameter int unsigned CW    = $clog2(SLOTS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx,
  output logic [CW-1:0] occ,
  output logic [CW-1:0] occ_nxt
);
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] occ_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(SLOTS - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    occ_nxt = occ_q;
    if (push && !pop)      occ_nxt = occ_q + 1'b1;
    else if (!push && pop) occ_nxt = occ_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      occ_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      occ_q <= occ_nxt;
    end
  end

  assign wr_idx = wr_q;
  assign rd_idx = rd_q;
  assign occ    = occ_q;
endmodule

// File: rtl/wbuf_drain_ctrl.sv
module wbuf_drain_ctrl
  import wbuf_pkg::*;
#(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned CW     = $clog2(SLOTS + 1),
  parameter int unsigned SYNC_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sync_we,
  input  logic [SYNC_W-1:0] sync_wdata,
  input  logic [CW-1:0]     occ_nxt,
  input  logic              pwr_req,
  output logic [SYNC_W-1:0] sync_status,
  output logic              up_ready,
  output logic              pwr_grant
);
  drain_state_e st_q, st_nxt;
  logic         arm, will_empty;
  logic         ready_q, grant_q;

  assign arm        = sync_we && (sync_wdata == SYNC_W'(SYNC_ARM));
  assign will_empty = (occ_nxt == '0);

  // a drain stays armed only while lines remain after this edge
  always_comb begin
    st_nxt = st_q;
    if ((st_q == DRN_ACTIVE || arm) && !will_empty) st_nxt = DRN_ACTIVE;
    else                                            st_nxt = DRN_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= DRN_IDLE;
      ready_q <= 1'b1;
      grant_q <= 1'b0;
    end else begin
      st_q    <= st_nxt;
      ready_q <= (occ_nxt < CW'(SLOTS)) && (st_nxt == DRN_IDLE) && !pwr_req;
      grant_q <= pwr_req && will_empty;
    end
  end

  assign sync_status = (st_q == DRN_ACTIVE) ? SYNC_W'(1) : '0;
  assign up_ready    = ready_q;
  assign pwr_grant   = grant_q;
endmodule

// File: rtl/cache_wbuf.sv
module cache_wbuf #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 256,
  parameter int unsigned SYNC_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                up_valid,
  output logic                up_ready,
  input  logic [AW-1:0]       up_addr,
  input  logic [DW-1:0]       up_data,
  input  logic [DW/8-1:0]     up_strb,
  output logic                mem_valid,
  input  logic                mem_ready,
  output logic [AW-1:0]       mem_addr,
  output logic [DW-1:0]       mem_data,
  output logic [DW/8-1:0]     mem_strb,
  input  logic                sync_we,
  input  logic [SYNC_W-1:0]   sync_wdata,
  output logic [SYNC_W-1:0]   sync_status,
  input  logic                pwr_req,
  output logic                pwr_grant
);
  localparam int unsigned SW = DW / 8;
  localparam int unsigned PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned CW = $clog2(SLOTS + 1);

  logic          push, pop;
  logic [PW-1:0] wr_idx, rd_idx;
  logic [CW-1:0] occ, occ_nxt;

  assign push      = up_valid && up_ready;
  assign mem_valid = (occ != '0);
  assign pop       = mem_valid && mem_ready;

  wbuf_queue_ctrl #(.SLOTS(SLOTS), .PW(PW), .CW(CW)) u_queue (
    .clk(clk), .rst(rst), .push(push), .pop(pop),
    .wr_idx(wr_idx), .rd_idx(rd_idx), .occ(occ), .occ_nxt(occ_nxt)
  );

  wbuf_slots #(.SLOTS(SLOTS), .AW(AW), .DW(DW), .SW(SW), .PW(PW)) u_slots (
    .clk(clk), .wr_en(push), .wr_idx(wr_idx),
    .wr_addr(up_addr), .wr_data(up_data), .wr_strb(up_strb),
    .rd_idx(rd_idx),
    .rd_addr(mem_addr), .rd_data(mem_data), .rd_strb(mem_strb)
  );

  wbuf_drain_ctrl #(.SLOTS(SLOTS), .CW(CW), .SYNC_W(SYNC_W)) u_drain (
    .clk(clk), .rst(rst), .sync_we(sync_we), .sync_wdata(sync_wdata),
    .occ_nxt(occ_nxt), .pwr_req(pwr_req),
    .sync_status(sync_status), .up_ready(up_ready), .pwr_grant(pwr_grant)
  );
endmodule

// File: rtl/wbuf_chk.sv
module wbuf_chk #(
  parameter int unsigned SLOTS  = 2,
  parameter int unsigned AW     = 32,
  parameter int unsigned DW     = 256,
  parameter int unsigned SYNC_W = 32,
  parameter int unsigned CW     = $clog2(SLOTS + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              up_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [AW-1:0]     mem_addr,
  input logic [DW-1:0]     mem_data,
  input logic [DW/8-1:0]   mem_strb,
  input logic [SYNC_W-1:0] sync_status,
  input logic              pwr_grant,
  input logic [CW-1:0]     occ
);
  // R2
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data) && $stable(mem_strb));

  // R3
  drain_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_status != '0) |-> !mem_valid);

  // R5
  drain_block_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_status != '0) |-> !up_ready);

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == CW'(SLOTS)) |-> !up_ready);

  // R7
  grant_empty_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_grant |-> !mem_valid);

  // R8
  reset_state_chk: assert property (@(posedge clk)
    rst |=> !mem_valid && (sync_status == '0) && !pwr_grant);
endmodule

bind cache_wbuf wbuf_chk #(.SLOTS(SLOTS), .AW(AW), .DW(DW), .SYNC_W(SYNC_W)) u_chk (
  .clk(clk), .rst(rst), .up_ready(up_ready), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data),
  .mem_strb(mem_strb), .sync_status(sync_status), .pwr_grant(pwr_grant),
  .occ(occ)
);

// File: tb/sim_cache_wbuf.sv
module sim_cache_wbuf;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         up_valid = 1'b0;
  logic         up_ready;
  logic [31:0]  up_addr = '0;
  logic [255:0] up_data = '0;
  logic [31:0]  up_strb = '0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [31:0]  mem_addr;
  logic [255:0] mem_data;
  logic [31:0]  mem_strb;
  logic         sync_we = 1'b0;
  logic [31:0]  sync_wdata = '0;
  logic [31:0]  sync_status;
  logic         pwr_req = 1'b0;
  logic         pwr_grant;

  int n_chk = 0;
  int n_bad = 0;
  int exp_k [256];
  int wr_n = 0;
  int rd_n = 0;
  bit sweep_on = 1'b0;
  bit finished = 1'b0;
  logic [7:0] lfsr = 8'hA7;

  always #10 clk = ~clk;

  cache_wbuf u0 (
    .clk(clk), .rst(rst), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_data(up_data), .up_strb(up_strb),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_strb(mem_strb), .sync_we(sync_we),
    .sync_wdata(sync_wdata), .sync_status(sync_status),
    .pwr_req(pwr_req), .pwr_grant(pwr_grant)
  );

  function automatic logic [31:0] g_addr(int k);
    return 32'h4000_0000 + 32'(k) * 32'd32;
  endfunction

  function automatic logic [255:0] g_data(int k);
    logic [255:0] r;
    for (int i = 0; i < 8; i++) r[i*32 +: 32] = 32'(k) * 32'h0100_0193 + 32'(i) * 32'h9E37_79B9;
    return r;
  endfunction

  function automatic logic [31:0] g_strb(int k);
    return (32'(k) * 32'h2545_F491) ^ 32'hA5A5_0F0F;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic drive_line(int k);
    up_addr = g_addr(k);
    up_data = g_data(k);
    up_strb = g_strb(k);
  endtask

  // holds a write until it is accepted; returns at the negedge after acceptance
  task automatic push(int k);
    @(negedge clk);
    drive_line(k);
    up_valid = 1'b1;
    while (!up_ready) @(negedge clk);
    exp_k[wr_n] = k;
    wr_n++;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  // memory responder log: compares every beat with the acceptance order (R1, R2)
  always begin
    @(negedge clk);
    #1;
    if (!rst && mem_valid && mem_ready) begin
      if (rd_n >= wr_n) begin
        chk(1'b0, "R2 beat with nothing pending", 32'(rd_n), 32'(wr_n));
      end else begin
        chk(mem_addr == g_addr(exp_k[rd_n]), "R2 order/address", mem_addr, g_addr(exp_k[rd_n]));
        chk(mem_data == g_data(exp_k[rd_n]), "R1 data", mem_data[31:0], g_data(exp_k[rd_n]) >> 0);
        chk(mem_strb == g_strb(exp_k[rd_n]), "R1 strobe", mem_strb, g_strb(exp_k[rd_n]));
        rd_n++;
      end
    end
  end

  // stall pattern used only during the sweep
  always @(posedge clk) begin
    if (sweep_on) begin
      #2;
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_ready = lfsr[0] | lfsr[2];
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'(rd_n), 32'(wr_n));
    summary();
  end

  initial begin
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8 reset state
    chk(up_ready == 1'b1, "R8 up_ready", 32'(up_ready), 1);
    chk(mem_valid == 1'b0, "R8 mem_valid", 32'(mem_valid), 0);
    chk(sync_status == 0, "R8 sync_status", sync_status, 0);
    chk(pwr_grant == 1'b0, "R8 pwr_grant", 32'(pwr_grant), 0);

    // streaming with memory always ready (R1, R2)
    mem_ready = 1'b1;
    for (int k = 1; k <= 4; k++) push(k);
    repeat (3) @(negedge clk);
    chk(rd_n == 4, "R2 streamed count", 32'(rd_n), 4);

    // R6 full back-pressure
    mem_ready = 1'b0;
    push(10);
    push(11);
    chk(up_ready == 1'b0, "R6 full ready low", 32'(up_ready), 0);
    held = mem_addr;
    @(negedge clk);
    chk(up_ready == 1'b0, "R6 full ready held", 32'(up_ready), 0);
    chk(mem_valid && mem_addr == held, "R2 stalled head stable", mem_addr, held);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(up_ready == 1'b1, "R6 ready after retire", 32'(up_ready), 1);
    chk(mem_addr == g_addr(11), "R2 second slot now head", mem_addr, g_addr(11));

    // R4 values other than 1 are ignored
    sync_we = 1'b1; sync_wdata = 32'd2;
    @(negedge clk);
    sync_wdata = 32'd3;
    @(negedge clk);
    sync_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    sync_we = 1'b0;
    @(negedge clk);
    chk(sync_status == 0, "R4 status stays zero", sync_status, 0);
    chk(up_ready == 1'b1, "R4 ready stays high", 32'(up_ready), 1);

    // R3/R5 drain with one pending line and a write waiting upstream
    sync_we = 1'b1; sync_wdata = 32'd1;
    @(negedge clk);
    sync_we = 1'b0; sync_wdata = '0;
    chk(sync_status == 32'd1, "R3 status after arm", sync_status, 1);
    chk(up_ready == 1'b0, "R5 intake blocked", 32'(up_ready), 0);
    drive_line(20);
    up_valid = 1'b1;
    repeat (2) @(negedge clk);
    chk(sync_status == 32'd1, "R3 status held while pending", sync_status, 1);
    chk(up_ready == 1'b0, "R5 intake still blocked", 32'(up_ready), 0);
    mem_ready = 1'b1;
    @(negedge clk);
    chk(sync_status == 0, "R3 status clear after last line", sync_status, 0);
    chk(up_ready == 1'b1, "R5 intake resumes", 32'(up_ready), 1);
    exp_k[wr_n] = 20;
    wr_n++;
    @(negedge clk);
    up_valid = 1'b0;
    repeat (3) @(negedge clk);
    chk(rd_n == wr_n, "R5 waiting write retired after drain", 32'(rd_n), 32'(wr_n));
    mem_ready = 1'b0;

    // R3 arming on an empty buffer leaves status at zero
    sync_we = 1'b1; sync_wdata = 32'd1;
    @(negedge clk);
    sync_we = 1'b0;
    chk(sync_status == 0, "R3 empty arm no effect", sync_status, 0);

    // R7 power grant only when empty
    push(30);
    pwr_req = 1'b1;
    @(negedge clk);
    chk(pwr_grant == 1'b0, "R7 no grant while pending", 32'(pwr_grant), 0);
    chk(up_ready == 1'b0, "R7 intake stopped by request", 32'(up_ready), 0);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    chk(pwr_grant == 1'b1, "R7 grant after empty", 32'(pwr_grant), 1);
    chk(mem_valid == 1'b0, "R7 empty at grant", 32'(mem_valid), 0);
    pwr_req = 1'b0;
    @(negedge clk);
    chk(pwr_grant == 1'b0, "R7 grant drops with request", 32'(pwr_grant), 0);
    chk(up_ready == 1'b1, "R7 intake back", 32'(up_ready), 1);

    // sweep under a pseudo-random stall pattern (R1, R2, R6)
    sweep_on = 1'b1;
    for (int k = 100; k < 220; k++) begin
      push(k);
      repeat (k % 3) @(negedge clk);
    end
    for (int t = 0; t < 200 && rd_n != wr_n; t++) @(negedge clk);
    sweep_on = 1'b0;
    chk(rd_n == wr_n, "R2 every line delivered", 32'(rd_n), 32'(wr_n));
    summary();
  end
endmodule